// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits between a serial bus byte engine and a non-volatile storage array. After the word address of a write transaction has been loaded, it gathers the data bytes that follow into a 16-lane byte latch. The low four bits of the address pointer select the lane. A valid flag per lane records which lanes were actually received. When the bus engine reports STOP, the block hands the whole page to the array in one request: the page number, the lane data and the lane mask. Only the lanes with a set mask bit are to be programmed, so the rest of the page keeps its old contents.

A commit opens a self-timed erase/write window. Its length is a parameterised number of tick pulses from an external time base. While the window is open, the block ignores every bus event and withholds the device-address acknowledge. A transaction is dropped without programming in several cases: it overruns the page, it meets a refused write permit, it contains no data, or it is cut off by a repeated START.

Top module: `pgwr_buffer`

## Requirements
- R1: In reset and on the first cycle after it, `busy`, `byte_ack`, `dev_ack` and `commit_req` are 0 and `ptr_out` is 0.
- R2: When a data byte is accepted, `byte_ack` is 1 on the cycle after the strobe.
  - A byte is accepted when the block is idle, a word address has been loaded, `wr_permit` is 1 and it is among the first 16 bytes.
  - The byte is stored in lane `ptr_out[3:0]`, which occupies bits `8*lane+7 : 8*lane` of `commit_data`.
  - After each accepted byte, `ptr_out[3:0]` advances by one with wrap from 15 to 0, and `ptr_out[9:4]` is unchanged.
- R3: A 17th or later data byte before STOP gets no ack and does not move the pointer, and the following STOP produces no commit and no busy window.
- R4: STOP after at least one accepted byte and no cancellation makes `commit_req` a one-cycle pulse on the cycle after STOP.
  - With that pulse, `commit_page` equals `ptr_out[9:4]`.
  - Bit i of `commit_mask` is 1 exactly for the lanes i that were received.
  - The lane data equals the received bytes.
- R5: `busy` rises on the same cycle as `commit_req` and falls after exactly `CYCLE_TICKS` tick pulses have been seen while it was high, whatever the spacing of the ticks.
- R6: While `busy` is 1, the block ignores `addr_load`, `data_stb`, `stop_evt` and `rstart_evt`: the pointer holds, no byte ack is given and no new commit starts. A `dev_sel` seen in such a cycle gets no `dev_ack`.
- R7: A data byte that arrives while `wr_permit` is 0 gets no ack and cancels the transaction. Later bytes of that transaction are not acked and its STOP commits nothing. `addr_load` still sets the pointer regardless of `wr_permit`.
- R8: STOP with no accepted data byte starts no commit and no busy window, and the pointer keeps the loaded address.
- R9: A repeated START discards the pending lanes while keeping the pointer. Data bytes arriving before a new word address are not acked, and the next STOP commits nothing.
- R10: `dev_sel` while idle gives `dev_ack` = 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_sel | input | 1 | Pulse: own device address seen on the bus |
| addr_load | input | 1 | Pulse: word address phase complete |
| addr_in | input | 10 | Word address loaded by `addr_load` |
| data_stb | input | 1 | Pulse: one data byte received |
| data_in | input | 8 | Byte qualified by `data_stb` |
| stop_evt | input | 1 | Pulse: STOP condition |
| rstart_evt | input | 1 | Pulse: repeated START condition |
| wr_permit | input | 1 | 1 when array writes are allowed (no write-protect, block writable) |
| tick | input | 1 | Time base pulse for the erase/write window |
| dev_ack | output | 1 | Acknowledge for the device address |
| byte_ack | output | 1 | Acknowledge for the previous data byte |
| busy | output | 1 | Erase/write window open |
| ptr_out | output | 10 | Current word address pointer |
| commit_req | output | 1 | One-cycle request to program the page |
| commit_page | output | 6 | Page number of the request |
| commit_mask | output | 16 | Lanes to program |
| commit_data | output | 128 | Lane data, lane i at bits 8i+7:8i |

## Verification
Two events can land on the same cycle: the end of the erase/write window and a new device-address strobe. The last tick retires `busy` on the very clock edge that sees the strobe. The bench counts cycles from STOP with a steady tick and places `dev_sel` on the final busy cycle. It then expects no acknowledge for that strobe, even though `busy` reads 0 when the result is sampled, and expects a normal acknowledge for a strobe one cycle later. It also issues address, data, STOP and device strobes inside the window and judges that the pointer, the acks and the commit line do not react.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // transaction phase of the collector
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,   // no word address pending
        TX_OPEN = 2'd1,   // collecting data bytes
        TX_DEAD = 2'd2    // overrun or refused: drop at STOP
    } tx_state_e;

    // bus events from the bit engine, bundled
    typedef struct packed {
        logic rstart;
        logic addr;
        logic stop;
        logic data;
    } bus_evt_t;

    // next in-page lane index, wrapping at the page size
    function automatic int unsigned lane_step(input int unsigned lane,
                                              input int unsigned lanes);
        return (lane + 1) % lanes;
    endfunction

endpackage

// File: rtl/pgwr_latch.sv
module pgwr_latch
    import pgwr_pkg::*;
#(
    parameter  int IDX_W = 4,
    localparam int NB    = 1 << IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 we,
    input  logic [IDX_W-1:0]     idx,
    input  byte_t                din,
    output logic [NB*BYTE_W-1:0] data_flat,
    output logic [NB-1:0]        valid
);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        byte_t lane_q;
        logic  vld_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= '0;
                vld_q  <= 1'b0;
            end else if (clr) begin
                vld_q  <= 1'b0;
            end else if (we && (idx == IDX_W'(g))) begin
                lane_q <= din;
                vld_q  <= 1'b1;
            end
        end

        assign data_flat[g*BYTE_W +: BYTE_W] = lane_q;
        assign valid[g]                      = vld_q;
    end

endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter  int ADDR_W = 10,
    parameter  int IDX_W  = 4,
    localparam int NB     = 1 << IDX_W,
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  bus_evt_t          evt,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_permit,
    output logic [ADDR_W-1:0] ptr,
    output logic              lat_we,
    output logic [IDX_W-1:0]  lat_idx,
    output logic              lat_clr,
    output logic              go,
    output logic              ack
);

    tx_state_e         state_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ack_q;
    logic              room;
    logic [IDX_W-1:0]  idx_nx;

    assign room    = cnt_q < CNT_W'(NB);
    assign idx_nx  = IDX_W'(lane_step(int'(ptr_q[IDX_W-1:0]), NB));
    assign lat_idx = ptr_q[IDX_W-1:0];

    // event decode; priority rstart > addr > stop > data, nothing while busy
    always_comb begin
        lat_we  = 1'b0;
        lat_clr = 1'b0;
        go      = 1'b0;
        if (!busy) begin
            if (evt.rstart || evt.addr) begin
                lat_clr = 1'b1;
            end else if (evt.stop) begin
                go = (state_q == TX_OPEN) && (cnt_q != '0);
            end else if (evt.data) begin
                lat_we = (state_q == TX_OPEN) && wr_permit && room;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            ptr_q   <= '0;
            cnt_q   <= '0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= lat_we;
            if (!busy) begin
                if (evt.rstart) begin
                    state_q <= TX_IDLE;
                    cnt_q   <= '0;
                end else if (evt.addr) begin
                    ptr_q   <= addr_in;
                    state_q <= TX_OPEN;
                    cnt_q   <= '0;
                end else if (evt.stop) begin
                    state_q <= TX_IDLE;
                end else if (evt.data && (state_q == TX_OPEN)) begin
                    if (lat_we) begin
                        ptr_q <= {ptr_q[ADDR_W-1:IDX_W], idx_nx};
                        cnt_q <= cnt_q + 1'b1;
                    end else begin
                        state_q <= TX_DEAD;
                    end
                end
            end
        end
    end

    assign ptr = ptr_q;
    assign ack = ack_q;

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter  int CYCLE_TICKS = 5000,
    localparam int TC_W        = $clog2(CYCLE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic tick,
    output logic busy,
    output logic req
);

    logic [TC_W-1:0] tc_q;
    logic            busy_q;
    logic            req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            req_q  <= 1'b0;
            tc_q   <= '0;
        end else begin
            req_q <= go;
            if (go) begin
                busy_q <= 1'b1;
                tc_q   <= '0;
            end else if (busy_q && tick) begin
                if (tc_q == TC_W'(CYCLE_TICKS - 1)) begin
                    busy_q <= 1'b0;
                end else begin
                    tc_q <= tc_q + 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign req  = req_q;

endmodule

// File: rtl/pgwr_buffer.sv
module pgwr_buffer
    import pgwr_pkg::*;
#(
    parameter  int ADDR_W      = 10,
    parameter  int IDX_W       = 4,
    parameter  int CYCLE_TICKS = 5000,
    localparam int NB          = 1 << IDX_W,
    localparam int PAGE_W      = ADDR_W - IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dev_sel,
    input  logic                 addr_load,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic                 data_stb,
    input  logic [BYTE_W-1:0]    data_in,
    input  logic                 stop_evt,
    input  logic                 rstart_evt,
    input  logic                 wr_permit,
    input  logic                 tick,
    output logic                 dev_ack,
    output logic                 byte_ack,
    output logic                 busy,
    output logic [ADDR_W-1:0]    ptr_out,
    output logic                 commit_req,
    output logic [PAGE_W-1:0]    commit_page,
    output logic [NB-1:0]        commit_mask,
    output logic [NB*BYTE_W-1:0] commit_data
);

    bus_evt_t         evt;
    logic             lat_we;
    logic             lat_clr;
    logic [IDX_W-1:0] lat_idx;
    logic             go;
    logic             busy_w;
    logic             dev_ack_q;

    assign evt = '{rstart: rstart_evt, addr: addr_load,
                   stop: stop_evt, data: data_stb};

    pgwr_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy_w),
        .evt      (evt),
        .addr_in  (addr_in),
        .wr_permit(wr_permit),
        .ptr      (ptr_out),
        .lat_we   (lat_we),
        .lat_idx  (lat_idx),
        .lat_clr  (lat_clr),
        .go       (go),
        .ack      (byte_ack)
    );

    pgwr_latch #(.IDX_W(IDX_W)) latch_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (lat_clr),
        .we       (lat_we),
        .idx      (lat_idx),
        .din      (data_in),
        .data_flat(commit_data),
        .valid    (commit_mask)
    );

    pgwr_timer #(.CYCLE_TICKS(CYCLE_TICKS)) timer_i (
        .clk (clk),
        .rst (rst),
        .go  (go),
        .tick(tick),
        .busy(busy_w),
        .req (commit_req)
    );

    // device address is refused while the erase/write window is open
    always_ff @(posedge clk) begin
        if (rst) dev_ack_q <= 1'b0;
        else     dev_ack_q <= dev_sel && !busy_w;
    end

    assign dev_ack     = dev_ack_q;
    assign busy        = busy_w;
    assign commit_page = ptr_out[ADDR_W-1:IDX_W];

endmodule

// File: rtl/pgwr_buffer_chk.sv
module pgwr_buffer_chk #(
    parameter  int ADDR_W      = 10,
    parameter  int IDX_W       = 4,
    parameter  int CYCLE_TICKS = 5000,
    localparam int NB          = 1 << IDX_W
) (
    input logic              clk,
    input logic              rst,
    input logic              dev_sel,
    input logic              data_stb,
    input logic              tick,
    input logic              dev_ack,
    input logic              byte_ack,
    input logic              busy,
    input logic [ADDR_W-1:0] ptr_out,
    input logic              commit_req,
    input logic [NB-1:0]     commit_mask
);

    // ticks consumed since the last commit, for the window check
    int unsigned tk_cnt;
    always_ff @(posedge clk) begin
        if (rst || commit_req) tk_cnt <= (busy && tick) ? 1 : 0;
        else if (busy && tick) tk_cnt <= tk_cnt + 1;
    end

    // R2
    ack_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
        byte_ack |-> $past(data_stb));

    // R10
    dev_ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        dev_ack |-> $past(dev_sel && !busy));

    // R4
    commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        commit_req |=> !commit_req);

    // R4
    commit_mask_chk: assert property (@(posedge clk) disable iff (rst)
        commit_req |-> (commit_mask != '0));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> commit_req);

    // R5
    busy_window_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !commit_req) |-> (tk_cnt < CYCLE_TICKS));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ptr_out));

endmodule

bind pgwr_buffer pgwr_buffer_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CYCLE_TICKS(CYCLE_TICKS)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .dev_sel    (dev_sel),
    .data_stb   (data_stb),
    .tick       (tick),
    .dev_ack    (dev_ack),
    .byte_ack   (byte_ack),
    .busy       (busy),
    .ptr_out    (ptr_out),
    .commit_req (commit_req),
    .commit_mask(commit_mask)
);

// File: tb/pgwr_buffer_tb_top.sv
module pgwr_buffer_tb_top;

    localparam int TB_TICKS = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         dev_sel = 0, addr_load = 0, data_stb = 0;
    logic         stop_evt = 0, rstart_evt = 0, wr_permit = 1;
    logic         tick = 1'b1;
    logic [9:0]   addr_in = '0;
    logic [7:0]   data_in = '0;
    logic         dev_ack, byte_ack, busy, commit_req;
    logic [9:0]   ptr_out;
    logic [5:0]   commit_page;
    logic [15:0]  commit_mask;
    logic [127:0] commit_data;

    int n_chk  = 0;
    int n_fail = 0;
    int tk_seen = 0;
    bit sparse = 1'b0;
    int div = 0;

    always #2 clk = ~clk;

    pgwr_buffer #(.CYCLE_TICKS(TB_TICKS)) dut_i (
        .clk(clk), .rst(rst), .dev_sel(dev_sel), .addr_load(addr_load),
        .addr_in(addr_in), .data_stb(data_stb), .data_in(data_in),
        .stop_evt(stop_evt), .rstart_evt(rstart_evt), .wr_permit(wr_permit),
        .tick(tick), .dev_ack(dev_ack), .byte_ack(byte_ack), .busy(busy),
        .ptr_out(ptr_out), .commit_req(commit_req), .commit_page(commit_page),
        .commit_mask(commit_mask), .commit_data(commit_data)
    );

    always @(negedge clk) begin
        div  = (div + 1) % 3;
        tick = sparse ? (div == 0) : 1'b1;
    end

    always @(posedge clk) if (busy && tick) tk_seen <= tk_seen + 1;

    task automatic chk(input bit ok, input string req,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic p_addr(input logic [9:0] a);
        @(negedge clk); addr_in = a; addr_load = 1;
        @(negedge clk); addr_load = 0;
    endtask

    task automatic p_byte(input logic [7:0] d, output bit a);
        @(negedge clk); data_in = d; data_stb = 1;
        @(negedge clk); data_stb = 0; a = byte_ack;
    endtask

    task automatic p_stop();
        @(negedge clk); stop_evt = 1;
        @(negedge clk); stop_evt = 0;
    endtask

    task automatic p_rstart();
        @(negedge clk); rstart_evt = 1;
        @(negedge clk); rstart_evt = 0;
    endtask

    task automatic p_dev(output bit a);
        @(negedge clk); dev_sel = 1;
        @(negedge clk); dev_sel = 0; a = dev_ack;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // {start address[22:13], byte count[12:8], seed[7:0]}
    localparam logic [22:0] VEC [8] = '{
        {10'h000, 5'd1,  8'h11},
        {10'h3F5, 5'd4,  8'h20},
        {10'h12E, 5'd5,  8'h40},
        {10'h250, 5'd16, 8'h80},
        {10'h1A3, 5'd16, 8'h05},
        {10'h077, 5'd17, 8'h33},
        {10'h300, 5'd20, 8'h90},
        {10'h0FF, 5'd2,  8'hC0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit a;
        int tk0, cyc;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && byte_ack == 0 && commit_req == 0 && dev_ack == 0,
            "R1 outputs", {busy, byte_ack, commit_req, dev_ack}, 0);
        chk(ptr_out == 0, "R1 ptr", ptr_out, 0);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && commit_req == 0, "R1 after release", busy, 0);

        // R10 idle device address
        p_dev(a);
        chk(a == 1, "R10 dev_ack", a, 1);

        // table walk: R2 R3 R4 R5
        foreach (VEC[v]) begin
            logic [9:0]  st;
            int          n, nacc;
            logic [7:0]  sd;
            logic [15:0] em;
            st = VEC[v][22:13]; n = int'(VEC[v][12:8]); sd = VEC[v][7:0];
            nacc = (n > 16) ? 16 : n;
            p_addr(st);
            for (int i = 0; i < n; i++) begin
                p_byte(sd + 8'(i), a);
                if (i < 16) chk(a == 1, "R2 ack", a, 1);
                else        chk(a == 0, "R3 no ack", a, 0);
            end
            chk(ptr_out == {st[9:4], 4'(st[3:0] + 4'(nacc))}, "R2 ptr",
                ptr_out, {st[9:4], 4'(st[3:0] + 4'(nacc))});
            p_stop();
            tk0 = tk_seen;
            if (n <= 16) begin
                em = '0;
                for (int i = 0; i < n; i++) em[4'(st[3:0] + 4'(i))] = 1'b1;
                chk(commit_req == 1, "R4 req", commit_req, 1);
                chk(busy == 1, "R5 busy rise", busy, 1);
                chk(commit_page == st[9:4], "R4 page", commit_page, st[9:4]);
                chk(commit_mask == em, "R4 mask", commit_mask, em);
                for (int i = 0; i < n; i++) begin
                    logic [3:0] ln;
                    ln = 4'(st[3:0] + 4'(i));
                    chk(commit_data[ln*8 +: 8] == sd + 8'(i), "R4 lane",
                        commit_data[ln*8 +: 8], sd + 8'(i));
                end
                @(negedge clk);
                chk(commit_req == 0, "R4 single pulse", commit_req, 0);
                wait_idle();
                chk(tk_seen - tk0 == TB_TICKS, "R5 window", tk_seen - tk0, TB_TICKS);
            end else begin
                chk(commit_req == 0 && busy == 0, "R3 dropped",
                    {commit_req, busy}, 0);
            end
        end

        // R7 write permit refused
        wr_permit = 0;
        p_addr(10'h155);
        chk(ptr_out == 10'h155, "R7 ptr loads", ptr_out, 10'h155);
        p_byte(8'h5A, a);
        chk(a == 0, "R7 refused ack", a, 0);
        wr_permit = 1;
        p_byte(8'h5B, a);
        chk(a == 0, "R7 cancelled ack", a, 0);
        p_stop();
        chk(commit_req == 0 && busy == 0, "R7 no commit", {commit_req, busy}, 0);
        chk(ptr_out == 10'h155, "R7 ptr held", ptr_out, 10'h155);

        // R8 pointer-only transaction
        p_addr(10'h2A7);
        p_stop();
        chk(commit_req == 0 && busy == 0, "R8 no commit", {commit_req, busy}, 0);
        chk(ptr_out == 10'h2A7, "R8 ptr", ptr_out, 10'h2A7);

        // R9 repeated start discards
        p_addr(10'h040);
        p_byte(8'h01, a);
        p_byte(8'h02, a);
        p_rstart();
        chk(ptr_out == 10'h042, "R9 ptr kept", ptr_out, 10'h042);
        p_byte(8'h03, a);
        chk(a == 0, "R9 no ack after rstart", a, 0);
        p_stop();
        chk(commit_req == 0 && busy == 0, "R9 no commit", {commit_req, busy}, 0);

        // R6 inputs ignored while busy
        p_addr(10'h310);
        p_byte(8'hAB, a);
        p_stop();
        chk(busy == 1, "R6 window open", busy, 1);
        p_addr(10'h000);
        chk(ptr_out == 10'h311, "R6 ptr held", ptr_out, 10'h311);
        p_byte(8'hCD, a);
        chk(a == 0, "R6 no byte ack", a, 0);
        p_dev(a);
        chk(a == 0, "R6 no dev ack", a, 0);
        p_stop();
        chk(commit_req == 0, "R6 no recommit", commit_req, 0);
        chk(busy == 1, "R6 still busy", busy, 1);
        wait_idle();

        // R6 R10 device strobe on the last busy cycle
        p_addr(10'h3C0);
        p_byte(8'h77, a);
        p_stop();
        repeat (TB_TICKS - 2) @(negedge clk);
        chk(busy == 1, "R6 last busy cycle", busy, 1);
        p_dev(a);
        chk(a == 0 && busy == 0, "R6 coincident strobe refused", {a, busy}, 0);
        p_dev(a);
        chk(a == 1, "R10 ack after window", a, 1);

        // R5 sparse ticks
        sparse = 1;
        p_addr(10'h0A0);
        p_byte(8'h99, a);
        p_stop();
        tk0 = tk_seen;
        cyc = 0;
        while (busy) begin @(negedge clk); cyc++; end
        chk(tk_seen - tk0 == TB_TICKS, "R5 sparse ticks", tk_seen - tk0, TB_TICKS);
        chk(cyc >= 2 * TB_TICKS, "R5 sparse length", cyc, 2 * TB_TICKS);
        sparse = 0;

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule